// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers up to 128 level-sensitive interrupt lines and presents them to a processor. The lines are grouped in banks of 32. Each bank has a mask word and a routing word, and the routing word sends every enabled source either to the normal interrupt output or to the fast interrupt output. Software reaches the block through a simple single-cycle register port. Writes take effect at the clock edge, and read data is a combinational function of the address.

A table of priority slots sets the order of service. Each slot holds a valid flag and a source number, and a lower slot number means a higher priority. The highest-priority register at offset 0x018 gives the winning source of each output path, each with its own valid flag. Software reads it to find out what to service, with no scan of the pending words. A wake output tells idle logic that something wants attention. A control bit selects whether masked sources may also cause a wake.

Sources must be synchronous to `clk`. `rst_n` is asserted asynchronously and must be released synchronously by the reset network outside the block.

Top module: `prio_intc`

## Requirements
- R1: After reset, every mask, routing and control bit and every priority slot is zero. `irq_out` and `fiq_out` are low, and the highest-priority register reads 0.
- R2: Bank b (b = 0..3, only where b·32 < NUM_SRC) sits at base 0x000, 0x09C, 0x130 or 0x244. Base+0x04 is the read/write mask word (1 = source enabled) and base+0x08 is the read/write routing word. Bit i of a bank word belongs to source 32·b+i, and bits for sources at or above NUM_SRC read 0.
- R3: Base+0x00 reads the sources that are active, enabled and routed to IRQ. Base+0x0C reads those active, enabled and routed to FIQ. Base+0x10 reads the raw source levels.
- R4: A routing bit of 0 selects IRQ and 1 selects FIQ. `irq_out` is high in the same cycle in which any source is active, enabled and routed to IRQ, and `fiq_out` behaves the same way for FIQ. No acknowledge is needed.
- R5: Priority slot s (s < NUM_SRC) sits at 0x01C+4s for s < 32, at 0x0B0+4(s−32) for s < 64 and at 0x144+4(s−64) above that. Bit 31 is the slot's valid flag and the low $clog2(NUM_SRC) bits hold a source number. A read returns these two fields and zeros elsewhere.
- R6: The register at 0x018 holds the IRQ winner in bit 31 (valid) and bits 30:16 (source). The winner is the source of the lowest-numbered valid slot whose source is active, enabled and routed to IRQ. When there is no such slot, both fields are 0.
- R7: The same register holds the FIQ winner in bit 15 (valid) and bits 14:0 (source), chosen by the same rule among FIQ-routed sources.
- R8: Slots with a clear valid flag, and slots naming a source at or above NUM_SRC, take no part in arbitration. A source named by several valid slots is reported at the lowest of them.
- R9: Bit 0 of the control word at 0x014 is read/write. When it is 1, `wake_out` is high only if a source is active and enabled. When it is 0, any active source raises `wake_out`.
- R10: Writes to unmapped or misaligned addresses, or to absent banks and slots, change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| src_lvl | input | NUM_SRC | Level-sensitive source lines |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |
| wake_out | output | 1 | Wake indication for idle logic |

## Verification
Both arbitration paths are resolved in the same cycle from one set of source levels. The two winners share one register word, so a fault in either half shows up in the same read. A long random sweep drives random sources, masks and routing words, and every so often a fresh random priority table that includes invalid slots and out-of-range source numbers. After each step the bench reads the combined word and compares both halves, the pending views and the three outputs against a model computed in the bench from the slot rules. Directed cases set up a single winner for each path, duplicate slots, and slots that point past the last source.

// File: rtl/ic_pkg.sv
`timescale 1ns/1ps
package ic_pkg;
  localparam int unsigned ADDR_W    = 10;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned MAX_BANKS = 4;
  localparam int unsigned MAX_SRC   = 128;

  typedef enum logic [3:0] {
    RK_NONE, RK_IPEND, RK_MASK, RK_LEVEL, RK_FPEND, RK_RAW, RK_CTRL, RK_HIGH, RK_PRIO
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
    logic [6:0] slot;
  } reg_sel_t;

  function automatic logic [ADDR_W-1:0] bank_base(input int unsigned b);
    case (b)
      0:       return 10'h000;
      1:       return 10'h09C;
      2:       return 10'h130;
      default: return 10'h244;
    endcase
  endfunction

  // bank 0 also carries the control and highest-priority words
  function automatic logic [ADDR_W-1:0] bank_span(input int unsigned b);
    return (b == 0) ? 10'h01C : 10'h014;
  endfunction

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr,
                                           input int unsigned       nsrc);
    reg_sel_t          sel;
    logic [ADDR_W-1:0] off;
    int unsigned       slot;
    sel.kind = RK_NONE;
    sel.bank = '0;
    sel.slot = '0;
    off      = '0;
    slot     = MAX_SRC;
    if (addr[1:0] == 2'b00) begin
      for (int unsigned b = 0; b < MAX_BANKS; b++) begin
        if ((b * BANK_W < nsrc) && (addr >= bank_base(b))) begin
          off = addr - bank_base(b);
          if (off < bank_span(b)) begin
            sel.bank = 2'(b);
            case (off[4:2])
              3'd0:    sel.kind = RK_IPEND;
              3'd1:    sel.kind = RK_MASK;
              3'd2:    sel.kind = RK_LEVEL;
              3'd3:    sel.kind = RK_FPEND;
              3'd4:    sel.kind = RK_RAW;
              3'd5:    sel.kind = RK_CTRL;
              3'd6:    sel.kind = RK_HIGH;
              default: sel.kind = RK_NONE;
            endcase
          end
        end
      end
      if (addr >= 10'h01C && addr < 10'h09C)
        slot = 32'(addr - 10'h01C) >> 2;
      else if (addr >= 10'h0B0 && addr < 10'h130)
        slot = 32'd32 + (32'(addr - 10'h0B0) >> 2);
      else if (addr >= 10'h144 && addr < 10'h244)
        slot = 32'd64 + (32'(addr - 10'h144) >> 2);
      if (slot < nsrc) begin
        sel.kind = RK_PRIO;
        sel.slot = 7'(slot);
      end
    end
    return sel;
  endfunction
endpackage

// File: rtl/ic_cfg_regs.sv
`timescale 1ns/1ps
module ic_cfg_regs
  import ic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  reg_kind_e          kind,
  input  logic [1:0]         bank,
  input  logic [DATA_W-1:0]  wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] level_q,
  output logic               ctrl_q
);
  logic [NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0] level_d;
  logic               ctrl_d;
  logic               cfg_we;

  assign cfg_we = wr_en && (kind == RK_MASK || kind == RK_LEVEL || kind == RK_CTRL);

  always_comb begin
    mask_d  = mask_q;
    level_d = level_q;
    ctrl_d  = ctrl_q;
    for (int unsigned i = 0; i < NUM_SRC; i++) begin
      if (bank == i[6:5]) begin
        if (kind == RK_MASK)  mask_d[i]  = wdata[i[4:0]];
        if (kind == RK_LEVEL) level_d[i] = wdata[i[4:0]];
      end
    end
    if (kind == RK_CTRL) ctrl_d = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      level_q <= '0;
      ctrl_q  <= 1'b0;
    end else if (cfg_we) begin
      mask_q  <= mask_d;
      level_q <= level_d;
      ctrl_q  <= ctrl_d;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mask_q) && $stable(level_q) && $stable(ctrl_q))); // R2
endmodule

// File: rtl/ic_prio_table.sv
`timescale 1ns/1ps
module ic_prio_table
  import ic_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 128,
  parameter int unsigned SRC_W     = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  reg_kind_e                       kind,
  input  logic [6:0]                      slot,
  input  logic                            wr_vld,
  input  logic [SRC_W-1:0]                wr_id,
  output logic [NUM_SLOTS-1:0]            slot_vld,
  output logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_id
);
  logic tbl_we;
  assign tbl_we = wr_en && (kind == RK_PRIO);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic             hit;
    logic             vld_q;
    logic             vld_d;
    logic [SRC_W-1:0] id_q;
    logic [SRC_W-1:0] id_d;

    assign hit = tbl_we && (slot == 7'(g));

    always_comb begin
      vld_d = vld_q;
      id_d  = id_q;
      if (hit) begin
        vld_d = wr_vld;
        id_d  = wr_id;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        id_q  <= '0;
      end else if (hit) begin
        vld_q <= vld_d;
        id_q  <= id_d;
      end
    end

    assign slot_vld[g] = vld_q;
    assign slot_id[g]  = id_q;
  end

  AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_we |=> ($stable(slot_vld) && $stable(slot_id))); // R5
endmodule

// File: rtl/ic_resolve.sv
`timescale 1ns/1ps
module ic_resolve #(
  parameter int unsigned NUM_SRC   = 128,
  parameter int unsigned NUM_SLOTS = 128,
  parameter int unsigned SRC_W     = 7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_SRC-1:0]              req,
  input  logic [NUM_SLOTS-1:0]            slot_vld,
  input  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_id,
  output logic                            hit,
  output logic [SRC_W-1:0]                win_id
);
  localparam int unsigned PAD_N = 2 ** SRC_W;

  // ids at or above NUM_SRC see a zero request
  logic [PAD_N-1:0] req_pad;

  always_comb begin
    req_pad              = '0;
    req_pad[NUM_SRC-1:0] = req;
  end

  always_comb begin
    hit    = 1'b0;
    win_id = '0;
    for (int unsigned s = 0; s < NUM_SLOTS; s++) begin
      if (!hit && slot_vld[s] && req_pad[slot_id[s]]) begin
        hit    = 1'b1;
        win_id = slot_id[s];
      end
    end
  end

  AST_WIN_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> req_pad[win_id]); // R8
  AST_QUIET_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> !hit); // R6
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
  import ic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               reg_wr_en,
  input  logic [9:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_out,
  output logic               fiq_out,
  output logic               wake_out
);
  localparam int unsigned SRC_W     = $clog2(NUM_SRC);
  localparam int unsigned NUM_SLOTS = NUM_SRC;
  localparam int unsigned NUM_PATHS = 2;

  reg_sel_t                        sel;
  logic [NUM_SRC-1:0]              mask_q;
  logic [NUM_SRC-1:0]              level_q;
  logic                            ctrl_q;
  logic [NUM_SLOTS-1:0]            slot_vld;
  logic [NUM_SLOTS-1:0][SRC_W-1:0] slot_id;
  logic [NUM_SRC-1:0]              live;
  logic [NUM_PATHS-1:0][NUM_SRC-1:0] path_req;
  logic [NUM_PATHS-1:0]            path_hit;
  logic [NUM_PATHS-1:0][SRC_W-1:0] path_id;
  logic [31:0]                     high_word;

  assign sel = decode_addr(reg_addr, NUM_SRC);

  ic_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .kind    (sel.kind),
    .bank    (sel.bank),
    .wdata   (reg_wdata),
    .mask_q  (mask_q),
    .level_q (level_q),
    .ctrl_q  (ctrl_q)
  );

  ic_prio_table #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .kind     (sel.kind),
    .slot     (sel.slot),
    .wr_vld   (reg_wdata[31]),
    .wr_id    (reg_wdata[SRC_W-1:0]),
    .slot_vld (slot_vld),
    .slot_id  (slot_id)
  );

  assign live        = src_lvl & mask_q;
  assign path_req[0] = live & ~level_q;
  assign path_req[1] = live & level_q;

  for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
    ic_resolve #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)) u_res (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (path_req[k]),
      .slot_vld (slot_vld),
      .slot_id  (slot_id),
      .hit      (path_hit[k]),
      .win_id   (path_id[k])
    );
  end

  assign irq_out   = |path_req[0];
  assign fiq_out   = |path_req[1];
  assign wake_out  = ctrl_q ? (|live) : (|src_lvl);
  assign high_word = {path_hit[0], 15'(path_id[0]), path_hit[1], 15'(path_id[1])};

  function automatic logic [31:0] bank_word(input logic [NUM_SRC-1:0] vec,
                                            input logic [1:0]         bank);
    logic [31:0] w;
    w = '0;
    for (int unsigned i = 0; i < NUM_SRC; i++)
      if (i[6:5] == bank) w[i[4:0]] = vec[i];
    return w;
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (sel.kind)
      RK_IPEND: reg_rdata = bank_word(path_req[0], sel.bank);
      RK_FPEND: reg_rdata = bank_word(path_req[1], sel.bank);
      RK_RAW:   reg_rdata = bank_word(src_lvl, sel.bank);
      RK_MASK:  reg_rdata = bank_word(mask_q, sel.bank);
      RK_LEVEL: reg_rdata = bank_word(level_q, sel.bank);
      RK_CTRL:  reg_rdata = {31'b0, ctrl_q};
      RK_HIGH:  reg_rdata = high_word;
      RK_PRIO: begin
        for (int unsigned s = 0; s < NUM_SLOTS; s++)
          if (sel.slot == 7'(s)) reg_rdata = {slot_vld[s], 31'(slot_id[s])};
      end
      default:  reg_rdata = '0;
    endcase
  end

  AST_IRQ_BEHIND_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    path_hit[0] |-> irq_out); // R6
  AST_FIQ_BEHIND_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    path_hit[1] |-> fiq_out); // R7
  AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (path_hit[0] && path_hit[1]) |-> (path_id[0] != path_id[1])); // R4
  AST_WAKE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out || fiq_out) |-> wake_out); // R9
endmodule

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  localparam int N  = 40;
  localparam int NB = (N + 31) / 32;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] src_lvl;
  logic         reg_wr_en;
  logic [9:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         irq_out;
  logic         fiq_out;
  logic         wake_out;

  bit [127:0] src_m;
  bit [127:0] m_mask;
  bit [127:0] m_level;
  bit         m_ctrl;
  bit         m_pv [128];
  int         m_pid[128];
  bit [63:0]  seed;
  int         total;
  int         bad;
  bit         done;

  assign src_lvl = src_m[N-1:0];

  prio_intc #(.NUM_SRC(N)) i_prio_intc (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out), .wake_out(wake_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int bbase(input int b);
    case (b)
      0: return 'h000;
      1: return 'h09C;
      2: return 'h130;
      default: return 'h244;
    endcase
  endfunction

  function automatic int saddr(input int s);
    if (s < 32) return 'h01C + 4 * s;
    if (s < 64) return 'h0B0 + 4 * (s - 32);
    return 'h144 + 4 * (s - 64);
  endfunction

  function automatic bit [31:0] bank_bits(input bit [127:0] v, input int b);
    bit [31:0] w;
    w = '0;
    for (int i = 0; i < 32; i++)
      if (b * 32 + i < N) w[i] = v[b * 32 + i];
    return w;
  endfunction

  function automatic bit [31:0] exp_high();
    bit iv, fv;
    int ii, fi;
    iv = 0; fv = 0; ii = 0; fi = 0;
    for (int s = 0; s < N; s++) begin
      if (m_pv[s] && m_pid[s] < N) begin
        if (src_m[m_pid[s]] && m_mask[m_pid[s]]) begin
          if (!m_level[m_pid[s]] && !iv) begin iv = 1; ii = m_pid[s]; end
          if (m_level[m_pid[s]] && !fv) begin fv = 1; fi = m_pid[s]; end
        end
      end
    end
    return {iv, 15'(ii), fv, 15'(fi)};
  endfunction

  function automatic bit [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input bit [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_addr  = 10'(a);
    reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 10'(a);
    #2;
    d = reg_rdata;
  endtask

  task automatic set_src(input bit [127:0] v);
    @(negedge clk);
    src_m = v;
  endtask

  task automatic set_mask(input int b, input bit [31:0] v);
    wr(bbase(b) + 4, v);
    for (int i = 0; i < 32; i++) if (b * 32 + i < N) m_mask[b * 32 + i] = v[i];
  endtask

  task automatic set_level(input int b, input bit [31:0] v);
    wr(bbase(b) + 8, v);
    for (int i = 0; i < 32; i++) if (b * 32 + i < N) m_level[b * 32 + i] = v[i];
  endtask

  task automatic set_slot(input int s, input bit v, input int id);
    wr(saddr(s), {v, 25'b0, 6'(id)});
    m_pv[s]  = v;
    m_pid[s] = id & 63;
  endtask

  task automatic check_table();
    logic [31:0] d;
    for (int s = 0; s < N; s++) begin
      rd(saddr(s), d);
      chk("R5", "slot readback", d, {m_pv[s], 25'b0, 6'(m_pid[s])});
    end
  endtask

  task automatic check_all();
    logic [31:0] d;
    bit [127:0] live;
    live = src_m & m_mask;
    for (int b = 0; b < NB; b++) begin
      rd(bbase(b) + 'h00, d); chk("R3", "irq pending", d, bank_bits(live & ~m_level, b));
      rd(bbase(b) + 'h0C, d); chk("R3", "fiq pending", d, bank_bits(live & m_level, b));
      rd(bbase(b) + 'h10, d); chk("R3", "raw", d, bank_bits(src_m, b));
      rd(bbase(b) + 'h04, d); chk("R2", "mask", d, bank_bits(m_mask, b));
      rd(bbase(b) + 'h08, d); chk("R2", "routing", d, bank_bits(m_level, b));
    end
    rd('h018, d);
    chk("R6 R7", "highest word", d, exp_high());
    chk("R4", "irq_out", {31'b0, irq_out}, {31'b0, |(live & ~m_level)});
    chk("R4", "fiq_out", {31'b0, fiq_out}, {31'b0, |(live & m_level)});
    chk("R9", "wake_out", {31'b0, wake_out}, {31'b0, m_ctrl ? |live : |src_m});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit [63:0]   r;
    total = 0; bad = 0; done = 0;
    seed = 64'h9E37_79B9_7F4A_7C15;
    src_m = '0; m_mask = '0; m_level = '0; m_ctrl = 0;
    for (int s = 0; s < 128; s++) begin m_pv[s] = 0; m_pid[s] = 0; end
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_all();
    rd('h014, d); chk("R1", "control after reset", d, 32'h0);
    check_table();
    set_src({88'b0, {N{1'b1}}});
    chk("R1", "irq_out masked at reset", {31'b0, irq_out}, 32'h0);
    check_all();

    // R9: control bit selects wake source
    wr('h014, 32'h1); m_ctrl = 1;
    rd('h014, d); chk("R9", "control readback", d, 32'h1);
    chk("R9", "wake with all masked", {31'b0, wake_out}, 32'h0);
    set_mask(1, 32'h0000_0004);
    chk("R9", "wake with one enabled", {31'b0, wake_out}, 32'h1);
    set_mask(1, 32'h0);
    wr('h014, 32'h0); m_ctrl = 0;
    chk("R9", "wake raw mode", {31'b0, wake_out}, 32'h1);

    // R6/R5: reverse table, single sources
    for (int s = 0; s < N; s++) set_slot(s, 1'b1, N - 1 - s);
    check_table();
    set_mask(0, 32'hFFFF_FFFF); set_mask(1, 32'hFFFF_FFFF);
    for (int j = 0; j < N; j++) begin
      set_src(128'(1) << j);
      rd('h018, d);
      chk("R6", "single irq winner", d, {1'b1, 15'(j), 16'h0});
    end
    // R7: same sources routed to FIQ
    set_level(0, 32'hFFFF_FFFF); set_level(1, 32'hFFFF_FFFF);
    for (int j = 0; j < N; j++) begin
      set_src(128'(1) << j);
      rd('h018, d);
      chk("R7", "single fiq winner", d, {16'h0, 1'b1, 15'(j)});
      chk("R4", "fiq level only", {30'b0, irq_out, fiq_out}, 32'h1);
    end
    // R6: pairs resolved by slot order
    set_level(0, 32'h0); set_level(1, 32'h0);
    for (int j = 0; j < N / 2; j++) begin
      set_src((128'(1) << j) | (128'(1) << (N - 1 - j)));
      rd('h018, d);
      chk("R6", "pair winner", d, {1'b1, 15'(N - 1 - j), 16'h0});
    end
    // R4: whole bank masked off
    set_src({88'b0, {N{1'b1}}});
    set_mask(0, 32'h0);
    check_all();
    set_mask(1, 32'h0);
    chk("R4", "all masked irq low", {31'b0, irq_out}, 32'h0);

    // R8: invalid, out-of-range and duplicate slots
    for (int s = 0; s < N; s++) set_slot(s, 1'b0, 0);
    set_mask(0, 32'hFFFF_FFFF); set_mask(1, 32'hFF);
    set_slot(0, 1'b1, 50);
    set_slot(1, 1'b0, 9);
    set_slot(3, 1'b1, 7);
    set_slot(5, 1'b1, 7);
    set_slot(6, 1'b1, 9);
    set_src((128'(1) << 7) | (128'(1) << 9) | (128'(1) << 20) | 128'(1));
    rd('h018, d); chk("R8", "duplicate and invalid", d, 32'h8007_0000);
    set_src((128'(1) << 9) | (128'(1) << 20) | 128'(1));
    rd('h018, d); chk("R8", "next valid slot", d, 32'h8009_0000);
    set_src((128'(1) << 20) | 128'(1));
    rd('h018, d); chk("R8", "no listed source", d, 32'h0);
    chk("R8", "irq_out still high", {31'b0, irq_out}, 32'h1);
    check_all();

    // R10: unmapped and misaligned writes
    wr('h0D0, 32'hFFFF_FFFF);
    wr('h0A2, 32'hFFFF_FFFF);
    wr('h248, 32'hFFFF_FFFF);
    wr('h3FC, 32'hFFFF_FFFF);
    rd('h0D0, d); chk("R10", "absent slot read", d, 32'h0);
    rd('h248, d); chk("R10", "absent bank read", d, 32'h0);
    rd('h3FC, d); chk("R10", "unmapped read", d, 32'h0);
    rd('h014, d); chk("R10", "control untouched", d, 32'h0);
    check_all();
    check_table();

    // R3/R4/R6/R7: random sweep
    for (int it = 0; it < 400; it++) begin
      if (it % 50 == 0) begin
        for (int s = 0; s < N; s++) begin
          r = rnd();
          set_slot(s, r[1:0] != 2'b00, int'(r[13:8]));
        end
        check_table();
      end
      r = rnd(); set_mask(0, r[31:0]); set_level(0, r[63:32]);
      r = rnd(); set_mask(1, r[31:0]); set_level(1, r[63:32]);
      r = rnd();
      if (it % 7 == 0) begin wr('h014, {31'b0, r[60]}); m_ctrl = r[60]; end
      set_src({88'b0, r[N-1:0]});
      check_all();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule